// File: doc/BRIEF.md
# Single-Bit Alias Bridge

This bridge sits between an upstream request port and a backing memory. It decodes a set of 32 MiB alias windows, where each aligned 32-bit word of a window stands for one bit of the backing memory. A read in a window returns that one bit. A write in a window sets or clears that bit by reading the containing unit of memory, changing the one bit and writing the unit back. Accesses to the backing memory use the size of the upstream request (1, 2 or 4 bytes) and are aligned to that size.

Two windows are decoded by default. Alias base 0x2200_0000 maps onto target base 0x2000_0000, and alias base 0x4200_0000 maps onto target base 0x4000_0000. A build parameter can leave every window unmapped. The read-modify-write is indivisible: no new upstream request is taken until its write-back has answered. Illegal sizes, addresses outside every window, and downstream errors are reported as an upstream error.

Top module: `bitband_bridge`

## Requirements
- R1: For an address whose bits [31:25] match a window's alias base, the downstream address is that window's target base ORed with (address bits [24:0] shifted right by 5). With the default parameters the windows are 0x2200_0000→0x2000_0000 and 0x4200_0000→0x4000_0000.
- R2: The downstream address is rounded down to a multiple of the request size, and mem_size equals req_size. The size is coded as a byte count of 1, 2 or 4.
- R3: The bit index is address bits [6:2] ANDed with (size×8−1). The downstream data is right-justified, with the byte at the lowest address in bits [7:0], and the index selects a bit of that value.
- R4: A read in a window responds with rsp_err 0 and the selected bit in rsp_rdata bit 0, with all other bits 0.
- R5: A write in a window issues exactly one downstream read and then one downstream write with the same address and size. The written value is the read value with the selected bit replaced by req_wdata bit 0. Bits [31:1] of req_wdata have no effect, and the write response carries rsp_rdata 0.
- R6: If the downstream read returns mem_err, the access ends with rsp_err 1 and no downstream write is issued.
- R7: req_ready stays low from the cycle a request is accepted until its response cycle has passed, so no request is taken while a downstream access is outstanding.
- R8: A req_size other than 1, 2 or 4 gives rsp_err 1 and causes no downstream access.
- R9: An address outside every window, or any address when ENABLE is 0, gives rsp_err 1 and causes no downstream access.
- R10: A mem_err on the downstream write is returned as rsp_err 1.
- R11: The downstream side may raise mem_resp in the same cycle as mem_ready, or some cycles later. Both are handled.
- R12: Out of reset, req_ready is 1 and rsp_valid and mem_valid are 0.
- R13: rsp_valid is a one-cycle pulse, given exactly once for each accepted request.
- R14: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_write and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 32 | Upstream alias address |
| req_size | input | 3 | Access size in bytes (1, 2, 4) |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| req_ready | output | 1 | Request accepted on a clock edge where it is high |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read result in bit 0 |
| rsp_err | output | 1 | Response error |
| mem_valid | output | 1 | Downstream request valid |
| mem_write | output | 1 | Downstream write |
| mem_addr | output | 32 | Downstream aligned byte address |
| mem_size | output | 3 | Downstream size in bytes |
| mem_wdata | output | 32 | Downstream write data, right-justified |
| mem_ready | input | 1 | Downstream request taken |
| mem_resp | input | 1 | Downstream response strobe |
| mem_rdata | input | 32 | Downstream read data, right-justified |
| mem_err | input | 1 | Downstream error with the response |

## Verification
Two events can land on the same clock edge: the downstream side taking the request (mem_ready) and its response (mem_resp). When they coincide, the bridge must go straight from issuing the request to handling the result, whether that result is a bit for a read or the start of the write-back. The bench drives a memory model whose ready latency and response delay change from one access to the next, including the zero-wait case where both strobes arrive together. In every case the returned bit and the final memory contents are compared against values the bench computes from the address arithmetic, and the bench checks that requests stay blocked while a downstream access is outstanding.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int SIZE_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RESP
  } bb_state_e;

  function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
    return (sz == SIZE_W'(1)) || (sz == SIZE_W'(2)) || (sz == SIZE_W'(4));
  endfunction

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 25,
  parameter int BIT_SH   = 5,
  parameter int NUM_WIN  = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000},
  parameter bit ENABLE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] phys
);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0]  win_phys [NUM_WIN];
  logic [ADDR_W-1:0]  word_off;

  assign word_off = {{TAG_W{1'b0}}, addr[WIN_BITS-1:0]} >> BIT_SH;

  generate
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      localparam logic [ADDR_W-1:0] ABASE = ALIAS_BASE[i*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] TBASE = TARGET_BASE[i*ADDR_W +: ADDR_W];
      assign win_hit[i]  = ENABLE && (addr[ADDR_W-1:WIN_BITS] == ABASE[ADDR_W-1:WIN_BITS]);
      assign win_phys[i] = TBASE | word_off;
    end
  endgenerate

  // lowest-numbered window wins when windows overlap
  always_comb begin
    hit  = 1'b0;
    phys = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        hit  = 1'b1;
        phys = win_phys[i];
      end
    end
  end

endmodule

// File: rtl/bb_lane_math.sv
module bb_lane_math #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] phys,
  input  logic [IDX_W-1:0]  word_sel,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] aligned,
  output logic [IDX_W-1:0]  bit_idx
);
  logic [IDX_W-1:0] idx_mask;

  always_comb begin
    case (size)
      SIZE_W'(1): idx_mask = IDX_W'(7);
      SIZE_W'(2): idx_mask = IDX_W'(15);
      default:    idx_mask = IDX_W'(31);
    endcase
  end

  assign bit_idx = word_sel & idx_mask;
  assign aligned = phys & ~(ADDR_W'(size) - ADDR_W'(1));

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              set_val,
  output logic              bit_val,
  output logic [DATA_W-1:0] merged
);
  logic [DATA_W-1:0] one_hot;

  assign one_hot = DATA_W'(1) << bit_idx;
  assign bit_val = word[bit_idx];
  assign merged  = set_val ? (word | one_hot) : (word & ~one_hot);

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 25,
  parameter int NUM_WIN  = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000},
  parameter bit ENABLE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [bb_pkg::SIZE_W-1:0]  req_size,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       req_ready,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       rsp_err,
  output logic                       mem_valid,
  output logic                       mem_write,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [bb_pkg::SIZE_W-1:0]  mem_size,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic                       mem_ready,
  input  logic                       mem_resp,
  input  logic [DATA_W-1:0]          mem_rdata,
  input  logic                       mem_err
);
  import bb_pkg::*;

  localparam int WORD_SH = $clog2(DATA_W / 8);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int BIT_SH  = WORD_SH + 3;

  bb_state_e           state;
  logic                dec_hit;
  logic [ADDR_W-1:0]   dec_phys;
  logic [ADDR_W-1:0]   lane_addr;
  logic [IDX_W-1:0]    lane_idx;
  logic [IDX_W-1:0]    idx_q;
  logic                set_q;
  logic                wr_q;
  logic                rd_ok_q;
  logic                rd_bit;
  logic [DATA_W-1:0]   wb_word;
  logic                rd_done;
  logic                wr_done;
  logic                unused_wdata;

  assign unused_wdata = ^req_wdata[DATA_W-1:1];

  bb_window_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BIT_SH(BIT_SH), .NUM_WIN(NUM_WIN),
    .ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE), .ENABLE(ENABLE)
  ) u_dec (
    .addr(req_addr), .hit(dec_hit), .phys(dec_phys)
  );

  bb_lane_math #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_lane (
    .phys(dec_phys), .word_sel(req_addr[WORD_SH +: IDX_W]), .size(req_size),
    .aligned(lane_addr), .bit_idx(lane_idx)
  );

  bb_bit_merge #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_merge (
    .word(mem_rdata), .bit_idx(idx_q), .set_val(set_q),
    .bit_val(rd_bit), .merged(wb_word)
  );

  assign req_ready = (state == ST_IDLE);
  assign rd_done   = mem_resp && (((state == ST_RD_REQ) && mem_ready) || (state == ST_RD_WAIT));
  assign wr_done   = mem_resp && (((state == ST_WR_REQ) && mem_ready) || (state == ST_WR_WAIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      idx_q     <= '0;
      set_q     <= 1'b0;
      wr_q      <= 1'b0;
      rd_ok_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          rd_ok_q <= 1'b0;
          if (req_valid) begin
            idx_q <= lane_idx;
            set_q <= req_wdata[0];
            wr_q  <= req_write;
            if (!size_legal(req_size) || !dec_hit) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
              state     <= ST_RESP;
            end else begin
              mem_valid <= 1'b1;
              mem_write <= 1'b0;
              mem_addr  <= lane_addr;
              mem_size  <= req_size;
              state     <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state     <= ST_RD_WAIT;
          end
        end
        ST_WR_REQ: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state     <= ST_WR_WAIT;
          end
        end
        ST_RESP: begin
          rsp_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: ;
      endcase

      // a response arriving with the request handshake overrides the wait step
      if (rd_done) begin
        if (mem_err) begin
          mem_valid <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_rdata <= '0;
          state     <= ST_RESP;
        end else if (wr_q) begin
          rd_ok_q   <= 1'b1;
          mem_valid <= 1'b1;
          mem_write <= 1'b1;
          mem_wdata <= wb_word;
          state     <= ST_WR_REQ;
        end else begin
          mem_valid <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= {{(DATA_W-1){1'b0}}, rd_bit};
          state     <= ST_RESP;
        end
      end

      if (wr_done) begin
        mem_valid <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_err   <= mem_err;
        rsp_rdata <= '0;
        state     <= ST_RESP;
      end
    end
  end

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);

  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ((mem_addr & (ADDR_W'(mem_size) - ADDR_W'(1))) == '0));

  p_size_legal_r8: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> size_legal(mem_size));

  p_rdata_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[DATA_W-1:1] == '0));

  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_hold_r14: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));

  p_wb_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_write) |-> rd_ok_q);

  p_err_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_done && mem_err) |=> !mem_valid);

endmodule

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0]  req_size = 3'd4;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic [2:0]  mem_size;
  logic        mem_ready, mem_resp, mem_err;
  logic [31:0] mem_rdata;

  logic        off_req_valid = 1'b0;
  logic        off_req_ready, off_rsp_valid, off_rsp_err;
  logic [31:0] off_rsp_rdata;
  logic        off_mem_valid, off_mem_write;
  logic [31:0] off_mem_addr, off_mem_wdata;
  logic [2:0]  off_mem_size;

  always #10 clk = ~clk;

  bitband_bridge u_dut (
    .clk, .rst, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
    .req_ready, .rsp_valid, .rsp_rdata, .rsp_err,
    .mem_valid, .mem_write, .mem_addr, .mem_size, .mem_wdata,
    .mem_ready, .mem_resp, .mem_rdata, .mem_err
  );

  bitband_bridge #(.ENABLE(1'b0)) u_dut_off (
    .clk(clk), .rst(rst), .req_valid(off_req_valid), .req_write(1'b0),
    .req_addr(32'h2200_0000), .req_size(3'd4), .req_wdata(32'h0),
    .req_ready(off_req_ready), .rsp_valid(off_rsp_valid), .rsp_rdata(off_rsp_rdata),
    .rsp_err(off_rsp_err), .mem_valid(off_mem_valid), .mem_write(off_mem_write),
    .mem_addr(off_mem_addr), .mem_size(off_mem_size), .mem_wdata(off_mem_wdata),
    .mem_ready(1'b0), .mem_resp(1'b0), .mem_rdata(32'h0), .mem_err(1'b0)
  );

  // ---------------- backing memory model ----------------
  logic [7:0]  bmem    [0:255];
  logic [7:0]  ref_mem [0:255];
  int          rdy_lat = 0;
  bit          resp_delay = 1'b0;
  bit          err_en = 1'b0, err_on_wr = 1'b0;
  logic [7:0]  err_addr = '0;
  int          wait_cnt = 0;
  logic        pend_v = 1'b0, pend_err = 1'b0;
  logic [31:0] pend_data = '0;
  logic [31:0] rdata_now;
  logic        err_now;

  always_comb begin
    rdata_now = '0;
    for (int b = 0; b < 4; b++)
      if (b < int'(mem_size)) rdata_now[8*b +: 8] = bmem[8'(mem_addr[7:0] + 8'(b))];
  end

  assign mem_ready = mem_valid && (wait_cnt >= rdy_lat);
  assign err_now   = mem_valid && mem_ready && err_en &&
                     (mem_addr[7:0] == err_addr) && (mem_write == err_on_wr);
  assign mem_resp  = resp_delay ? pend_v    : (mem_valid && mem_ready);
  assign mem_rdata = resp_delay ? pend_data : rdata_now;
  assign mem_err   = resp_delay ? pend_err  : err_now;

  always @(posedge clk) begin
    wait_cnt  <= (mem_valid && !mem_ready) ? wait_cnt + 1 : 0;
    pend_v    <= mem_valid && mem_ready;
    pend_data <= rdata_now;
    pend_err  <= err_now;
    if (mem_valid && mem_write && mem_ready && !err_now)
      for (int b = 0; b < 4; b++)
        if (b < int'(mem_size)) bmem[8'(mem_addr[7:0] + 8'(b))] <= mem_wdata[8*b +: 8];
  end

  // ---------------- monitor ----------------
  int          rd_cnt = 0, wr_cnt = 0, overlap_cnt = 0, acc_cnt = 0, rsp_cnt = 0;
  int          dbl_rsp = 0, off_mem_seen = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [2:0]  last_rd_size = '0, last_wr_size = '0;
  logic        prev_rsp = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_valid && mem_ready) begin
        if (mem_write) begin wr_cnt++; last_wr_addr = mem_addr; last_wr_size = mem_size; end
        else           begin rd_cnt++; last_rd_addr = mem_addr; last_rd_size = mem_size; end
      end
      if (mem_valid && req_ready) overlap_cnt++;
      if (req_valid && req_ready) acc_cnt++;
      if (rsp_valid) rsp_cnt++;
      if (rsp_valid && prev_rsp) dbl_rsp++;
      prev_rsp = rsp_valid;
      if (off_mem_valid) off_mem_seen++;
    end
  end

  // ---------------- checking helpers ----------------
  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [31:0] a, input logic [2:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_phys(input int win, input logic [24:0] off, input int sz);
    logic [31:0] base;
    logic [31:0] p;
    base = (win == 0) ? 32'h2000_0000 : 32'h4000_0000;
    p = base | (32'(off) >> 5);
    return p & ~(32'(sz) - 32'd1);
  endfunction

  function automatic int exp_idx(input logic [24:0] off, input int sz);
    return int'((off >> 2) & 25'(sz * 8 - 1));
  endfunction

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 256; i++) if (bmem[i] !== ref_mem[i]) d++;
    return d;
  endfunction

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tests, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd, a, pa;
    logic        er;
    logic [24:0] off;
    int          sizes [3];
    int          r0, w0, idx, bi, sz;
    logic        expb, setv;
    sizes[0] = 1; sizes[1] = 2; sizes[2] = 4;
    for (int i = 0; i < 256; i++) begin
      bmem[i]    = 8'((i * 37 + 11) ^ (i >> 3));
      ref_mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(req_ready === 1'b1, "R12 req_ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid === 1'b0, "R12 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check(mem_valid === 1'b0, "R12 mem_valid after reset", 32'(mem_valid), 32'd0);

    // read sweep: R1 R2 R3 R4 R11
    for (int win = 0; win < 2; win++)
      for (int s = 0; s < 3; s++)
        for (int w = 0; w < 256; w++) begin
          sz  = sizes[s];
          off = 25'(w * 4) | ((w % 5 == 0) ? 25'h1F0_0000 : 25'h0);
          a   = ((win == 0) ? 32'h2200_0000 : 32'h4200_0000) | 32'(off);
          rdy_lat = w % 3; resp_delay = w[2];
          pa  = exp_phys(win, off, sz);
          idx = exp_idx(off, sz);
          expb = ref_mem[8'(pa[7:0] + 8'(idx / 8))][idx % 8];
          r0 = rd_cnt; w0 = wr_cnt;
          access(1'b0, a, 3'(sz), 32'h0, rd, er);
          check(rd === {31'b0, expb} && er === 1'b0, "R4 R3 R11 read bit", rd, {31'b0, expb});
          check(last_rd_addr === pa && last_rd_size === 3'(sz), "R1 R2 read address", last_rd_addr, pa);
          check(rd_cnt == r0 + 1 && wr_cnt == w0, "R4 read traffic", 32'(rd_cnt - r0), 32'd1);
        end

    // write sweep: R5 R3 R11
    for (int win = 0; win < 2; win++)
      for (int s = 0; s < 3; s++)
        for (int w = 0; w < 64; w++) begin
          sz  = sizes[s];
          off = 25'(w * 12 + win * 520);
          a   = ((win == 0) ? 32'h2200_0000 : 32'h4200_0000) | 32'(off);
          rdy_lat = (w + s) % 3; resp_delay = w[1];
          setv = w[0] ^ w[3];
          pa  = exp_phys(win, off, sz);
          idx = exp_idx(off, sz);
          bi  = int'(8'(pa[7:0] + 8'(idx / 8)));
          ref_mem[bi][idx % 8] = setv;
          r0 = rd_cnt; w0 = wr_cnt;
          access(1'b1, a, 3'(sz), {31'h5EAD_BEE7 ^ 31'(w), setv}, rd, er);
          check(rd === 32'h0 && er === 1'b0, "R5 write response", rd, 32'h0);
          check(mem_diff() == 0, "R5 R3 memory after write", 32'(mem_diff()), 32'd0);
          check(rd_cnt == r0 + 1 && wr_cnt == w0 + 1 && last_wr_addr === last_rd_addr &&
                last_wr_size === last_rd_size && last_wr_addr === pa,
                "R5 RMW address and count", last_wr_addr, pa);
        end

    // R11 zero-wait directed: ready and response together
    rdy_lat = 0; resp_delay = 1'b0;
    pa = exp_phys(0, 25'h0000_0A4, 4);
    idx = exp_idx(25'h0000_0A4, 4);
    ref_mem[8'(pa[7:0] + 8'(idx / 8))][idx % 8] = 1'b1;
    access(1'b1, 32'h2200_00A4, 3'd4, 32'h1, rd, er);
    check(er === 1'b0 && mem_diff() == 0, "R11 zero-wait write", 32'(mem_diff()), 32'd0);
    expb = ref_mem[8'(pa[7:0] + 8'(idx / 8))][idx % 8];
    access(1'b0, 32'h2200_00A4, 3'd4, 32'h0, rd, er);
    check(rd === {31'b0, expb}, "R11 zero-wait read back", rd, {31'b0, expb});

    // R8 illegal sizes
    for (int k = 0; k < 8; k++) begin
      if (k == 1 || k == 2 || k == 4) continue;
      r0 = rd_cnt; w0 = wr_cnt;
      access(1'b1, 32'h2200_0040, 3'(k), 32'h1, rd, er);
      check(er === 1'b1 && rd === 32'h0, "R8 illegal size error", 32'(er), 32'd1);
      check(rd_cnt == r0 && wr_cnt == w0 && mem_diff() == 0, "R8 no downstream access",
            32'(rd_cnt - r0 + wr_cnt - w0), 32'd0);
    end

    // R9 unmapped addresses
    foreach (sizes[k]) begin
      a = (k == 0) ? 32'h3000_0000 : (k == 1) ? 32'h2400_0000 : 32'h21FF_FFFC;
      r0 = rd_cnt;
      access(1'b0, a, 3'd4, 32'h0, rd, er);
      check(er === 1'b1 && rd_cnt == r0, "R9 unmapped address error", 32'(er), 32'd1);
    end
    @(negedge clk) off_req_valid = 1'b1;
    @(negedge clk) off_req_valid = 1'b0;
    while (!off_rsp_valid) @(negedge clk);
    check(off_rsp_err === 1'b1 && off_mem_seen == 0, "R9 disabled windows error", 32'(off_rsp_err), 32'd1);

    // R6 downstream read error on a write and on a read
    rdy_lat = 1; resp_delay = 1'b1;
    pa = exp_phys(1, 25'h0000_200, 2);
    err_en = 1'b1; err_on_wr = 1'b0; err_addr = pa[7:0];
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 32'h4200_0200, 3'd2, 32'h1, rd, er);
    check(er === 1'b1, "R6 read error reported", 32'(er), 32'd1);
    check(wr_cnt == w0 && rd_cnt == r0 + 1 && mem_diff() == 0, "R6 no write-back",
          32'(wr_cnt - w0), 32'd0);
    resp_delay = 1'b0; rdy_lat = 0;
    access(1'b0, 32'h4200_0200, 3'd2, 32'h0, rd, er);
    check(er === 1'b1 && rd === 32'h0, "R6 read op error", 32'(er), 32'd1);

    // R10 write-back error
    err_on_wr = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b1, 32'h4200_0200, 3'd2, 32'h1, rd, er);
    check(er === 1'b1, "R10 write-back error reported", 32'(er), 32'd1);
    check(rd_cnt == r0 + 1 && wr_cnt == w0 + 1 && mem_diff() == 0, "R10 one read one write",
          32'(wr_cnt - w0), 32'd1);
    err_en = 1'b0;

    // R7 R13 R14 global observations
    check(overlap_cnt == 0, "R7 ready low while downstream busy", 32'(overlap_cnt), 32'd0);
    check(acc_cnt == rsp_cnt, "R13 one response per request", 32'(rsp_cnt), 32'(acc_cnt));
    check(dbl_rsp == 0, "R13 single-cycle response", 32'(dbl_rsp), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule